// File: doc/BRIEF.md
# BCD Game Score Accumulator

This block keeps the running score of a nine-round guessing game as a packed pair of decimal digits. Each round, the game logic pulses a one-cycle strobe together with a two-bit verdict on the player's guess. The block turns the verdict into a point value and adds it to the stored score with decimal carry correction, so each nibble always stays a legal decimal digit.

A round counter counts the accepted strobes. Once the configured number of rounds has been scored, the score is locked and a completion flag is raised. Only a reset unlocks it. Both digits are also decoded into active-high seven-segment patterns, which can drive a pair of displays directly. Debouncing, the guess comparison itself and display multiplexing belong to the surrounding logic.

Top module: `score_accum`

## Requirements
- R1: An active-high synchronous reset sets the score to 0x00 and drops the completion flag at the next rising clock edge. After that edge both seven-segment outputs show the pattern for zero (0x3F).
- R2: A strobe accepted with verdict 2'b10 (exact) adds 9 points. Verdict 2'b01 (low) adds 4 points. Verdict 2'b00 (high) adds 0 points. The reserved verdict 2'b11 also adds 0 points.
- R3: The score is packed BCD, with the tens digit in bits [7:4] and the units digit in bits [3:0]. Each nibble stays in the range 0 to 9 at all times, and a units sum above 9 wraps and carries one into the tens digit.
- R4: The score changes only on a rising edge where the strobe is high and the game is not complete. One accepted strobe produces exactly one addition.
- R5: The completion flag rises on the edge that accepts the ninth strobe after reset, and it stays high until reset.
- R6: While the completion flag is high, strobes are ignored and the score holds its value, whatever the verdict.
- R7: Each seven-segment output is active high in gfedcba bit order (bit 0 = segment a). Digit k occupies bits [7k+6:7k] of the segment bus. Digits 0 to 9 use the patterns 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F.
- R8: When reset and a strobe fall in the same cycle, reset wins: the score becomes 0x00 and that strobe is not counted as a round.
- R9: Nine exact verdicts give the largest possible score, 0x81, and no carry ever leaves the tens digit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| round_stb | input | 1 | One-cycle pulse marking a scored round |
| guess | input | 2 | Verdict for the round: 00 high, 01 low, 10 exact, 11 reserved |
| total_bcd | output | 8 | Packed BCD score, tens digit in the upper nibble |
| seg_bus | output | 14 | Seven-segment patterns, units in [6:0], tens in [13:7] |
| done | output | 1 | High once all rounds have been scored |

## Verification
Two functions can meet in one cycle: the reset and a round strobe. In some games the bench raises both on the same edge partway through, then continues the game. The score must read 00, and the following nine strobes must still be counted as a full fresh game before the flag rises.

The ninth accepted strobe is a second such meeting, because it both adds points and locks the score. It is judged by checking that its points appear in the score while later strobes of every verdict leave the score untouched.

// File: rtl/score_pkg.sv
package score_pkg;

    localparam int NIB_W = 4;
    localparam int SEG_W = 7;

    typedef logic [NIB_W-1:0] bcd_t;
    typedef logic [SEG_W-1:0] seg_t;

    typedef enum logic [1:0] {
        VERDICT_HIGH  = 2'b00,
        VERDICT_LOW   = 2'b01,
        VERDICT_EXACT = 2'b10,
        VERDICT_RSVD  = 2'b11
    } verdict_e;

    typedef struct packed {
        logic cout;
        bcd_t digit;
    } dsum_t;

    // Point value of one verdict, as a single decimal digit.
    function automatic bcd_t verdict_points(verdict_e v, bcd_t exact_pts, bcd_t low_pts);
        bcd_t p;
        case (v)
            VERDICT_EXACT: p = exact_pts;
            VERDICT_LOW:   p = low_pts;
            default:       p = '0;
        endcase
        return p;
    endfunction

    // One decimal digit add with correction by six.
    function automatic dsum_t bcd_digit_add(bcd_t a, bcd_t b, logic cin);
        logic [NIB_W:0] raw;
        logic [NIB_W:0] fixed;
        dsum_t r;
        raw = {1'b0, a} + {1'b0, b} + {{NIB_W{1'b0}}, cin};
        if (raw > 5'd9) begin
            fixed   = raw + 5'd6;
            r.digit = fixed[NIB_W-1:0];
            r.cout  = 1'b1;
        end else begin
            r.digit = raw[NIB_W-1:0];
            r.cout  = 1'b0;
        end
        return r;
    endfunction

    // Active-high gfedcba pattern, blank for non-decimal codes.
    function automatic seg_t seg_pattern(bcd_t d);
        seg_t s;
        case (d)
            4'd0:    s = 7'h3F;
            4'd1:    s = 7'h06;
            4'd2:    s = 7'h5B;
            4'd3:    s = 7'h4F;
            4'd4:    s = 7'h66;
            4'd5:    s = 7'h6D;
            4'd6:    s = 7'h7D;
            4'd7:    s = 7'h07;
            4'd8:    s = 7'h7F;
            4'd9:    s = 7'h6F;
            default: s = 7'h00;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/score_digit_add.sv
module score_digit_add
    import score_pkg::*;
(
    input  bcd_t a_i,
    input  bcd_t b_i,
    input  logic cin_i,
    output bcd_t sum_o,
    output logic cout_o
);

    dsum_t res;

    always_comb begin
        res    = bcd_digit_add(a_i, b_i, cin_i);
        sum_o  = res.digit;
        cout_o = res.cout;
    end

endmodule

// File: rtl/score_round_ctr.sv
module score_round_ctr #(
    parameter int ROUNDS = 9
) (
    input  logic clk,
    input  logic rst,
    input  logic stb_i,
    output logic accept_o,
    output logic done_o
);

    localparam int CNT_W = $clog2(ROUNDS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ROUNDS);

    logic [CNT_W-1:0] cnt_q;

    assign done_o   = (cnt_q == LAST);
    assign accept_o = stb_i & ~done_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (accept_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/score_seg_enc.sv
module score_seg_enc
    import score_pkg::*;
(
    input  bcd_t digit_i,
    output seg_t seg_o
);

    assign seg_o = seg_pattern(digit_i);

endmodule

// File: rtl/score_accum.sv
module score_accum
    import score_pkg::*;
#(
    parameter int ROUNDS    = 9,
    parameter int DIGITS    = 2,
    parameter int PTS_EXACT = 9,
    parameter int PTS_LOW   = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      round_stb,
    input  logic [1:0]                guess,
    output logic [DIGITS*NIB_W-1:0]   total_bcd,
    output logic [DIGITS*SEG_W-1:0]   seg_bus,
    output logic                      done
);

    localparam int TOT_W = DIGITS * NIB_W;

    logic [TOT_W-1:0] total_q;
    logic [TOT_W-1:0] sum_c;
    logic [DIGITS:0]  carry_c;
    bcd_t             pts_c;
    logic             accept;

    score_round_ctr #(.ROUNDS(ROUNDS)) ctr_i (
        .clk      (clk),
        .rst      (rst),
        .stb_i    (round_stb),
        .accept_o (accept),
        .done_o   (done)
    );

    assign pts_c      = verdict_points(verdict_e'(guess), bcd_t'(PTS_EXACT), bcd_t'(PTS_LOW));
    assign carry_c[0] = 1'b0;

    for (genvar k = 0; k < DIGITS; k++) begin : g_digit
        bcd_t addend;
        if (k == 0) begin : g_lsd
            assign addend = pts_c;
        end else begin : g_upper
            assign addend = '0;
        end

        score_digit_add add_i (
            .a_i    (total_q[k*NIB_W +: NIB_W]),
            .b_i    (addend),
            .cin_i  (carry_c[k]),
            .sum_o  (sum_c[k*NIB_W +: NIB_W]),
            .cout_o (carry_c[k+1])
        );

        score_seg_enc enc_i (
            .digit_i (total_q[k*NIB_W +: NIB_W]),
            .seg_o   (seg_bus[k*SEG_W +: SEG_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            total_q <= '0;
        end else if (accept) begin
            total_q <= sum_c;
        end
    end

    assign total_bcd = total_q;

endmodule

// File: rtl/score_accum_chk.sv
module score_accum_chk #(
    parameter int DIGITS = 2
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  round_stb,
    input logic [1:0]            guess,
    input logic [DIGITS*4-1:0]   total_bcd,
    input logic                  done,
    input logic                  top_carry
);

    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (total_bcd == '0) && !done);

    // R3
    for (genvar k = 0; k < DIGITS; k++) begin : g_rng
        a_r3_digit_range: assert property (@(posedge clk) disable iff (rst)
            total_bcd[k*4 +: 4] <= 4'd9);
    end

    // R4
    a_r4_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !round_stb |=> $stable(total_bcd));

    // R2
    a_r2_exact_units: assert property (@(posedge clk) disable iff (rst)
        (round_stb && !done && guess == 2'b10) |=>
        (total_bcd[3:0] == 4'(({28'd0, $past(total_bcd[3:0])} + 32'd9) % 32'd10)));

    a_r2_zero_points: assert property (@(posedge clk) disable iff (rst)
        (round_stb && (guess == 2'b00 || guess == 2'b11)) |=> $stable(total_bcd));

    // R5
    a_r5_done_sticky: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    a_r5_done_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(round_stb));

    // R6
    a_r6_frozen: assert property (@(posedge clk) disable iff (rst)
        done |=> $stable(total_bcd));

    // R9
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (round_stb && !done) |-> !top_carry);

endmodule

bind score_accum score_accum_chk #(.DIGITS(DIGITS)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .round_stb (round_stb),
    .guess     (guess),
    .total_bcd (total_bcd),
    .done      (done),
    .top_carry (carry_c[DIGITS])
);

// File: tb/score_accum_tb_top.sv
module score_accum_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ROUNDS     = 9;
    localparam int GAMES      = 240;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        round_stb = 1'b0;
    logic [1:0]  guess = 2'b00;
    logic [7:0]  total_bcd;
    logic [13:0] seg_bus;
    logic        done;

    int checks = 0;
    int fails  = 0;
    int m_sum   = 0;
    int m_round = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    score_accum dut_i (
        .clk       (clk),
        .rst       (rst),
        .round_stb (round_stb),
        .guess     (guess),
        .total_bcd (total_bcd),
        .seg_bus   (seg_bus),
        .done      (done)
    );

    function automatic logic [6:0] exp_seg(int d);
        case (d)
            0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
            4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
            8: return 7'h7F; 9: return 7'h6F;
            default: return 7'h00;
        endcase
    endfunction

    function automatic int pts_for(logic [1:0] g);
        return (g == 2'b10) ? 9 : (g == 2'b01) ? 4 : 0;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Compare all outputs against the arithmetic model.
    task automatic check_state(string req);
        int tens, units;
        tens  = m_sum / 10;
        units = m_sum % 10;
        check(req, "total", int'(total_bcd), tens * 16 + units);
        check(req, "done", int'(done), (m_round == ROUNDS) ? 1 : 0);
        check("R7", "seg units", int'(seg_bus[6:0]), int'(exp_seg(units)));
        check("R7", "seg tens", int'(seg_bus[13:7]), int'(exp_seg(tens)));
    endtask

    task automatic do_reset(bit with_stb, logic [1:0] g);
        @(negedge clk);
        rst = 1'b1; round_stb = with_stb; guess = g;
        @(negedge clk);
        rst = 1'b0; round_stb = 1'b0;
        m_sum = 0; m_round = 0;
        check_state(with_stb ? "R8" : "R1");
    endtask

    task automatic do_round(logic [1:0] g, int gap);
        @(negedge clk);
        round_stb = 1'b1; guess = g;
        @(negedge clk);
        round_stb = 1'b0;
        if (m_round < ROUNDS) begin
            m_sum += pts_for(g);
            m_round++;
            check_state(m_round == ROUNDS ? "R5" : "R2");
        end else begin
            check_state("R6");
        end
        for (int i = 0; i < gap; i++) begin
            @(negedge clk);
            guess = 2'(i + g);
            check_state("R4");
        end
    endtask

    initial begin
        do_reset(0, 2'b00);
        check("R1", "seg zero", int'(seg_bus), {7'h3F, 7'h3F});
        for (int g = 0; g < GAMES; g++) begin
            for (int r = 0; r < ROUNDS + 2; r++) begin
                logic [1:0] v;
                if (g == 0)      v = 2'b10;
                else if (g == 1) v = 2'b01;
                else if (g == 2) v = 2'b00;
                else if (g == 3) v = 2'b11;
                else             v = 2'((g * 7 + r * 3 + (g >> 2) * r) % 4);
                do_round(v, (g + r) % 3);
                if (g % 5 == 4 && r == 3) do_reset(1, 2'b10);
            end
            if (g == 0) check("R9", "max score", int'(total_bcd), 8'h81);
            do_reset(0, 2'b00);
        end
        finished = 1;
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("  test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

endmodule